// File: doc/BRIEF.md
# Flag-Generating Integer ALU

This block is the integer datapath of a small processor core. It takes an opcode, a byte/word size select, a destination operand, a source operand and the current flag set. In the same cycle it produces a result and the write-back enables. The updated flag set is captured in a register on the next rising clock edge. The register file and the flag storage sit outside the block. The block gives back flags that merge the bits the operation changes with the bits it must preserve from `flags_i`.

The block covers add, add with carry, subtract, subtract with borrow, compare, increment, decrement, negate, the four bitwise logic functions, a non-storing AND test, and two sign-extension steps. Each operation touches its own subset of flags. Compare and test produce flags but request no write. Increment and decrement keep the carry. Inversion and sign extension keep every flag.

Top module: `flag_alu`

## Requirements
- R1: Opcode 0 (add) gives dst+src and opcode 1 (add with carry) gives dst+src+CF_in. Both assert `wb_en_o` and update all six flags: CF is the carry out of the sign bit, AF the carry out of bit 3, and OF is set when both addends share a sign that the result does not have.
- R2: Opcode 2 (subtract) gives dst-src, opcode 3 (subtract with borrow) gives dst-src-CF_in, and opcode 7 (negate) gives 0-dst. All three write back and update all six flags: CF is the borrow out of the sign bit, AF the borrow out of bit 3, and OF is set when the operand signs differ and the result sign differs from the minuend sign.
- R3: Opcode 4 (compare) updates flags exactly as subtract does, holds `wb_en_o` low, and sets ZF exactly when the operands are equal.
- R4: Opcode 5 (increment, dst+1) and opcode 6 (decrement, dst-1) write back and update AF, OF, PF, SF and ZF. CF keeps its incoming value.
- R5: Opcodes 8, 9 and 10 (AND, OR, XOR of dst and src) write back, force CF and OF to 0, keep AF at its incoming value, and set PF, SF and ZF from the result.
- R6: Opcode 11 (test) sets flags exactly as AND does and holds `wb_en_o` low.
- R7: Opcode 12 inverts every bit of dst within the selected size, writes back, and leaves all six flags at their incoming values.
- R8: Opcode 13 returns the low byte of dst with bit 7 copied into bits 15:8. Opcode 14 returns dst unchanged and drives `res_hi_o` with 16 copies of dst bit 15, asserting `wb_hi_en_o`. Neither depends on `wide_i` or changes any flag. Every other opcode holds `wb_hi_en_o` low and `res_hi_o` at 0.
- R9: With `wide_i`=0, only bits 7:0 of the operands are used, bit 7 is the sign bit, the carry/borrow is taken out of bit 7, ZF tests bits 7:0, and bits 15:8 of `res_o` are 0. With `wide_i`=1, the same rules apply to bit 15 and bits 15:0.
- R10: PF is 1 exactly when bits 7:0 of the result hold an even number of ones, in both sizes.
- R11: The flag vector uses bit order {OF,SF,ZF,AF,PF,CF} from bit 5 down to bit 0. `flags_o` takes the updated value on the rising edge after the inputs are applied and is cleared to 0 by a synchronous active-low reset.
- R12: Opcode 15 is reserved. It holds both write enables low and leaves all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the flag register |
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | 1 selects 16-bit operation, 0 selects 8-bit |
| dst_i | input | 16 | Destination operand |
| src_i | input | 16 | Source operand |
| flags_i | input | 6 | Current flags {OF,SF,ZF,AF,PF,CF} |
| res_o | output | 16 | Result (low word) |
| res_hi_o | output | 16 | High word of the word-to-double extension |
| wb_en_o | output | 1 | Result is to be written back |
| wb_hi_en_o | output | 1 | High word is to be written back |
| flags_o | output | 6 | Registered updated flags {OF,SF,ZF,AF,PF,CF} |

## Verification
The hardest cases to reach are the signed-overflow and carry boundaries with a borrow-in of one in byte mode while the upper operand bits hold garbage. At the same time, preserved flags must survive operations that only partly update them. The stimulus sweeps every third byte destination against strided and hand-picked source values such as 0x7F, 0x80 and 0xFF, with both carry-in values, under a varying incoming flag pattern and nonzero upper bytes. Word mode is covered by a pseudo-random operand stream plus fixed boundary pairs around 0x7FFF and 0xFFFF. A second-cycle check confirms that `flags_o` changes only on the edge after the inputs are applied.

// File: rtl/alu_pkg.sv
// Shared types for the flag-generating ALU.
// Assumes the flag vector ordering {OF,SF,ZF,AF,PF,CF}, bit 5 down to 0.
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_CMP  = 4'd4,
        OP_INC  = 4'd5,
        OP_DEC  = 4'd6,
        OP_NEG  = 4'd7,
        OP_AND  = 4'd8,
        OP_OR   = 4'd9,
        OP_XOR  = 4'd10,
        OP_TEST = 4'd11,
        OP_NOT  = 4'd12,
        OP_B2W  = 4'd13,
        OP_W2D  = 4'd14,
        OP_RSV  = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_INV = 2'd3
    } logic_fn_e;

    localparam int NFLAG = 6;
    localparam int FL_CF = 0;
    localparam int FL_PF = 1;
    localparam int FL_AF = 2;
    localparam int FL_ZF = 3;
    localparam int FL_SF = 4;
    localparam int FL_OF = 5;

endpackage

// File: rtl/alu_addsub.sv
// Shared adder/subtractor with size-selected carry and sign tap.
// Subtraction is done as a + ~b + ~cin, so the reported carry is the
// borrow (inverted carry out). Assumes W is even and at least 8.
module alu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    input  logic         wide,
    output logic [W-1:0] res,
    output logic         cf,
    output logic         af,
    output logic         of
);
    localparam int H = W / 2;

    logic [W-1:0] b_eff;
    logic         c0;
    logic [W:0]   full_sum;
    logic [H:0]   half_sum;
    logic [4:0]   nib_sum;
    logic         cout;
    logic         sgn_a;
    logic         sgn_b;
    logic         sgn_r;

    // Form the sums for both sizes plus the low nibble for the half carry.
    always_comb begin
        b_eff    = sub ? ~b : b;
        c0       = sub ^ cin;
        full_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
        half_sum = {1'b0, a[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, c0};
        nib_sum  = {1'b0, a[3:0]} + {1'b0, b_eff[3:0]} + {4'b0000, c0};
    end

    // Select the size, then derive carry/borrow, half carry and overflow.
    always_comb begin
        cout  = wide ? full_sum[W]   : half_sum[H];
        sgn_a = wide ? a[W-1]        : a[H-1];
        sgn_b = wide ? b_eff[W-1]    : b_eff[H-1];
        sgn_r = wide ? full_sum[W-1] : half_sum[H-1];
        res   = wide ? full_sum[W-1:0] : {{(W-H){1'b0}}, half_sum[H-1:0]};
        cf    = cout ^ sub;
        af    = nib_sum[4] ^ sub;
        of    = (sgn_a == sgn_b) && (sgn_r != sgn_a);
    end

endmodule

// File: rtl/alu_logic.sv
// Bitwise unit: AND, OR, XOR of two operands or inversion of the first.
// The result is cleared above the low half when byte size is selected.
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         wide,
    input  logic_fn_e    fn,
    output logic [W-1:0] res
);
    localparam int H = W / 2;

    logic [W-1:0] mask;
    logic [W-1:0] raw;

    // Compute the raw bitwise function and clip it to the operand size.
    always_comb begin
        mask = wide ? {W{1'b1}} : {{(W-H){1'b0}}, {H{1'b1}}};
        case (fn)
            LG_AND:  raw = a & b;
            LG_OR:   raw = a | b;
            LG_XOR:  raw = a ^ b;
            default: raw = ~a;
        endcase
        res = raw & mask;
    end

endmodule

// File: rtl/alu_flagcalc.sv
// Result-derived flags: parity of the low byte, sign and zero for the
// selected size. Assumes W is at least 8 and the result is already clipped.
module alu_flagcalc #(
    parameter int W = 16
) (
    input  logic [W-1:0] res,
    input  logic         wide,
    output logic         pf,
    output logic         sf,
    output logic         zf
);
    localparam int H = W / 2;

    // Derive the three result flags.
    always_comb begin
        pf = ~(^res[7:0]);
        sf = wide ? res[W-1] : res[H-1];
        zf = wide ? (res == '0) : (res[H-1:0] == '0);
    end

endmodule

// File: rtl/flag_alu.sv
// Integer ALU top: steers operands into the shared adder and the logic
// unit, picks the result and write enables, merges new flags into the
// incoming set per opcode, and registers the merged flags.
// Assumes W is even and at least 8; flags_i is the architectural flag set.
module flag_alu
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_i,
    input  logic             wide_i,
    input  logic [W-1:0]     dst_i,
    input  logic [W-1:0]     src_i,
    input  logic [NFLAG-1:0] flags_i,
    output logic [W-1:0]     res_o,
    output logic [W-1:0]     res_hi_o,
    output logic             wb_en_o,
    output logic             wb_hi_en_o,
    output logic [NFLAG-1:0] flags_o
);
    localparam int H = W / 2;

    alu_op_e          op;
    logic [W-1:0]     as_a;
    logic [W-1:0]     as_b;
    logic             as_cin;
    logic             as_sub;
    logic [W-1:0]     as_res;
    logic             as_cf;
    logic             as_af;
    logic             as_of;
    logic_fn_e        lg_fn;
    logic [W-1:0]     lg_res;
    logic [W-1:0]     core_res;
    logic             pf;
    logic             sf;
    logic             zf;
    logic [NFLAG-1:0] next_flags;
    logic [NFLAG-1:0] flags_q;

    assign op = alu_op_e'(op_i);

    // Steer operands, carry-in and direction into the shared adder.
    always_comb begin
        as_a   = dst_i;
        as_b   = src_i;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op)
            OP_ADC: as_cin = flags_i[FL_CF];
            OP_SUB: as_sub = 1'b1;
            OP_SBB: begin
                as_sub = 1'b1;
                as_cin = flags_i[FL_CF];
            end
            OP_CMP: as_sub = 1'b1;
            OP_INC: as_b   = {{(W-1){1'b0}}, 1'b1};
            OP_DEC: begin
                as_b   = {{(W-1){1'b0}}, 1'b1};
                as_sub = 1'b1;
            end
            OP_NEG: begin
                as_a   = '0;
                as_b   = dst_i;
                as_sub = 1'b1;
            end
            default: ;
        endcase
    end

    // Choose the bitwise function for the logic unit.
    always_comb begin
        case (op)
            OP_OR:   lg_fn = LG_OR;
            OP_XOR:  lg_fn = LG_XOR;
            OP_NOT:  lg_fn = LG_INV;
            default: lg_fn = LG_AND;
        endcase
    end

    alu_addsub #(.W(W)) u_addsub (
        .a    (as_a),
        .b    (as_b),
        .cin  (as_cin),
        .sub  (as_sub),
        .wide (wide_i),
        .res  (as_res),
        .cf   (as_cf),
        .af   (as_af),
        .of   (as_of)
    );

    alu_logic #(.W(W)) u_logic (
        .a    (dst_i),
        .b    (src_i),
        .wide (wide_i),
        .fn   (lg_fn),
        .res  (lg_res)
    );

    // Select the result, the high word and the write enables.
    always_comb begin
        core_res   = as_res;
        res_hi_o   = '0;
        wb_en_o    = 1'b1;
        wb_hi_en_o = 1'b0;
        case (op)
            OP_CMP: wb_en_o = 1'b0;
            OP_AND, OP_OR, OP_XOR, OP_NOT: core_res = lg_res;
            OP_TEST: begin
                core_res = lg_res;
                wb_en_o  = 1'b0;
            end
            OP_B2W: core_res = {{(W-H){dst_i[H-1]}}, dst_i[H-1:0]};
            OP_W2D: begin
                core_res   = dst_i;
                res_hi_o   = {W{dst_i[W-1]}};
                wb_hi_en_o = 1'b1;
            end
            OP_RSV: begin
                core_res = '0;
                wb_en_o  = 1'b0;
            end
            default: ;
        endcase
    end

    assign res_o = core_res;

    alu_flagcalc #(.W(W)) u_flagcalc (
        .res  (core_res),
        .wide (wide_i),
        .pf   (pf),
        .sf   (sf),
        .zf   (zf)
    );

    // Merge freshly computed flags into the incoming set per opcode.
    always_comb begin
        next_flags = flags_i;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP, OP_NEG: begin
                next_flags[FL_CF] = as_cf;
                next_flags[FL_AF] = as_af;
                next_flags[FL_OF] = as_of;
                next_flags[FL_PF] = pf;
                next_flags[FL_SF] = sf;
                next_flags[FL_ZF] = zf;
            end
            OP_INC, OP_DEC: begin
                next_flags[FL_AF] = as_af;
                next_flags[FL_OF] = as_of;
                next_flags[FL_PF] = pf;
                next_flags[FL_SF] = sf;
                next_flags[FL_ZF] = zf;
            end
            OP_AND, OP_OR, OP_XOR, OP_TEST: begin
                next_flags[FL_CF] = 1'b0;
                next_flags[FL_OF] = 1'b0;
                next_flags[FL_PF] = pf;
                next_flags[FL_SF] = sf;
                next_flags[FL_ZF] = zf;
            end
            default: ;
        endcase
    end

    // Hold the updated flags; cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= next_flags;
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/flag_alu_chk.sv
// Property checker for flag_alu, attached with bind. Observes ports only.
module flag_alu_chk
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op_i,
    input logic [NFLAG-1:0] flags_i,
    input logic             wb_en_o,
    input logic             wb_hi_en_o,
    input logic [NFLAG-1:0] flags_o
);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (flags_o == '0));

    // R3
    cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMP) |-> !wb_en_o);

    // R4
    incdec_cf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_INC || op_i == OP_DEC) |=> (flags_o[FL_CF] == $past(flags_i[FL_CF])));

    // R5
    logic_cfof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= OP_AND && op_i <= OP_TEST) |=> (!flags_o[FL_CF] && !flags_o[FL_OF]));

    // R5
    logic_af_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= OP_AND && op_i <= OP_TEST) |=> (flags_o[FL_AF] == $past(flags_i[FL_AF])));

    // R7
    inv_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NOT) |=> (flags_o == $past(flags_i)));

    // R8
    ext_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_B2W || op_i == OP_W2D) |=> (flags_o == $past(flags_i)));

    // R8
    hi_enable_only_w2d_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_W2D) |-> !wb_hi_en_o);

    // R12
    rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RSV) |=> (flags_o == $past(flags_i)));

endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op_i),
    .flags_i    (flags_i),
    .wb_en_o    (wb_en_o),
    .wb_hi_en_o (wb_hi_en_o),
    .flags_o    (flags_o)
);

// File: tb/sim_flag_alu.sv
module sim_flag_alu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic        wide_i = 1'b0;
    logic [15:0] dst_i = '0;
    logic [15:0] src_i = '0;
    logic [5:0]  flags_i = '0;
    logic [15:0] res_o;
    logic [15:0] res_hi_o;
    logic        wb_en_o;
    logic        wb_hi_en_o;
    logic [5:0]  flags_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_alu #(.W(16)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op_i),
        .wide_i     (wide_i),
        .dst_i      (dst_i),
        .src_i      (src_i),
        .flags_i    (flags_i),
        .res_o      (res_o),
        .res_hi_o   (res_hi_o),
        .wb_en_o    (wb_en_o),
        .wb_hi_en_o (wb_hi_en_o),
        .flags_o    (flags_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string op_tag(input int op);
        case (op)
            0, 1:     return "R1";
            2, 3, 7:  return "R2";
            4:        return "R3";
            5, 6:     return "R4";
            8, 9, 10: return "R5";
            11:       return "R6";
            12:       return "R7";
            13, 14:   return "R8";
            default:  return "R12";
        endcase
    endfunction

    // Arithmetic reference with flags in order {OF,SF,ZF,AF,PF,CF}.
    task automatic model(input int op, input bit wide, input int d, input int s,
                         input bit [5:0] fi, output int r, output int rh,
                         output bit wb, output bit wh, output bit [5:0] fo);
        int m, sb, dm, sm, a, b, cc, raw, sa, sbv, sr, half;
        bit cf, af, ov, pf, sf, zf, arith, is_sub, logicop;
        m  = wide ? 'hFFFF : 'hFF;
        sb = wide ? 15 : 7;
        dm = d & m;
        sm = s & m;
        fo = fi; rh = 0; wb = 1'b1; wh = 1'b0; r = 0;
        arith = 1'b0; is_sub = 1'b0; logicop = 1'b0;
        a = dm; b = sm; cc = 0;
        case (op)
            0: arith = 1'b1;
            1: begin arith = 1'b1; cc = fi[0]; end
            2, 4: begin arith = 1'b1; is_sub = 1'b1; end
            3: begin arith = 1'b1; is_sub = 1'b1; cc = fi[0]; end
            5: begin arith = 1'b1; b = 1; end
            6: begin arith = 1'b1; is_sub = 1'b1; b = 1; end
            7: begin arith = 1'b1; is_sub = 1'b1; a = 0; b = dm; end
            8, 11: begin logicop = 1'b1; r = dm & sm; end
            9:  begin logicop = 1'b1; r = dm | sm; end
            10: begin logicop = 1'b1; r = dm ^ sm; end
            12: r = (~dm) & m;
            13: r = (d & 'h80) != 0 ? ((d & 'hFF) | 'hFF00) : (d & 'hFF);
            14: begin r = d & 'hFFFF; rh = (d & 'h8000) != 0 ? 'hFFFF : 0; wh = 1'b1; end
            default: wb = 1'b0;
        endcase
        if (op == 4 || op == 11) wb = 1'b0;
        sa  = ((a >> sb) & 1) != 0 ? a - (m + 1) : a;
        sbv = ((b >> sb) & 1) != 0 ? b - (m + 1) : b;
        if (arith) begin
            if (is_sub) begin
                raw  = a - b - cc;
                half = (a & 15) - (b & 15) - cc;
                sr   = sa - sbv - cc;
                cf   = raw < 0;
                af   = half < 0;
            end else begin
                raw  = a + b + cc;
                half = (a & 15) + (b & 15) + cc;
                sr   = sa + sbv + cc;
                cf   = raw > m;
                af   = half > 15;
            end
            r  = raw & m;
            ov = (sr > (m >> 1)) || (sr < -((m >> 1) + 1));
        end
        pf = ~(^(r[7:0]));
        zf = (r == 0);
        sf = ((r >> sb) & 1) != 0;
        if (arith) begin
            if (op != 5 && op != 6) fo[0] = cf;
            fo[2] = af; fo[5] = ov; fo[1] = pf; fo[4] = sf; fo[3] = zf;
        end else if (logicop) begin
            fo[0] = 1'b0; fo[5] = 1'b0; fo[1] = pf; fo[4] = sf; fo[3] = zf;
        end
    endtask

    task automatic apply(input int op, input bit wide, input int d, input int s, input bit [5:0] fi);
        int r, rh; bit wb, wh; bit [5:0] fo; string tg;
        model(op, wide, d, s, fi, r, rh, wb, wh, fo);
        tg = wide ? op_tag(op) : {op_tag(op), "/R9"};
        @(negedge clk);
        op_i = op[3:0]; wide_i = wide; dst_i = d[15:0]; src_i = s[15:0]; flags_i = fi;
        #1;
        chk(tg, "res", int'(res_o), r);
        chk(tg, "wb_en", int'(wb_en_o), int'(wb));
        chk(tg, "wb_hi_en", int'(wb_hi_en_o), int'(wh));
        chk(tg, "res_hi", int'(res_hi_o), rh);
        @(posedge clk); #1;
        chk(tg, "flags", int'(flags_o), int'(fo));
    endtask

    function automatic int src_pick(input int si);
        case (si)
            16: return 'h01;
            17: return 'h7F;
            18: return 'h80;
            19: return 'h81;
            20: return 'hFE;
            default: return si * 17;
        endcase
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lfsr;
        flags_i = 6'h3F;
        op_i = 4'd12;
        repeat (3) @(posedge clk);
        #1;
        chk("R11", "reset flags", int'(flags_o), 0);
        @(negedge clk); rst_n = 1'b1;

        // R11: flags change only on the edge after the inputs are applied.
        apply(12, 1'b1, 'h1234, 0, 6'h2A);
        @(negedge clk); op_i = 4'd12; flags_i = 6'h15; #1;
        chk("R11", "flags before edge", int'(flags_o), 'h2A);
        @(posedge clk); #1;
        chk("R11", "flags after edge", int'(flags_o), 'h15);

        // R10: parity of low byte in both sizes.
        apply(0, 1'b0, 'h03, 'h00, 6'h00);
        chk("R10", "pf even", int'(flags_o[1]), 1);
        apply(0, 1'b0, 'h01, 'h00, 6'h00);
        chk("R10", "pf odd", int'(flags_o[1]), 0);
        apply(0, 1'b1, 'h0100, 'h0000, 6'h00);
        chk("R10", "pf word low byte zero", int'(flags_o[1]), 1);

        // R3: equal operands set ZF.
        apply(4, 1'b1, 'hBEEF, 'hBEEF, 6'h00);
        chk("R3", "zf on equal", int'(flags_o[3]), 1);

        // Word boundary pairs.
        for (int op = 0; op < 16; op++) begin
            apply(op, 1'b1, 'h7FFF, 'h0001, 6'h01);
            apply(op, 1'b1, 'hFFFF, 'h0001, 6'h00);
            apply(op, 1'b1, 'h8000, 'h0001, 6'h3F);
            apply(op, 1'b1, 'h0000, 'h8000, 6'h01);
            apply(op, 1'b1, 'h0000, 'h0000, 6'h00);
        end

        // Byte sweep with garbage in the upper operand bytes.
        for (int op = 0; op < 16; op++)
            for (int di = 0; di < 86; di++)
                for (int si = 0; si < 21; si++)
                    for (int c = 0; c < 2; c++)
                        apply(op, 1'b0, (di * 3) | (((di * 37) & 'hFF) << 8),
                              src_pick(si) | (((si * 53) & 'hFF) << 8),
                              6'(((di + si) * 11 & 'h3E) | c));

        // Word sweep from a pseudo-random stream.
        lfsr = 32'h1ACE_B00C;
        for (int op = 0; op < 16; op++)
            for (int k = 0; k < 1500; k++) begin
                lfsr = (lfsr >>> 1 & 32'h7FFF_FFFF) ^ ((lfsr & 1) != 0 ? 32'hA300_0000 : 0);
                apply(op, 1'b1, lfsr & 'hFFFF, (lfsr >>> 16) & 'hFFFF, 6'((lfsr >>> 10) & 'h3F));
            end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule